// File: doc/BRIEF.md
# Pointer-Addressed Two-Wire Serial Target

This block is a target on a two-wire serial bus that fronts a small register file of four 16-bit locations. Both bus lines are sampled against a fast system clock through a synchronizer chain. The block drives SDA only through an open-drain pull-down enable. It detects bus START, repeated START and STOP conditions and compares the 7-bit device address with its own. After a write address it takes a pointer byte that selects a register, and then one or two data bytes, depending on the register selected. After a read address it returns the register that was last selected, and that selection survives from one transaction to the next.

On the chip side, the register file sits outside the block. The block presents the current selection on `reg_sel` and reads the 16-bit value on `reg_rd_data`. A completed write comes out as a single-cycle pulse on `reg_wr_en` with `reg_wr_data`. A pointer byte outside the register range is passed on as an opcode on `cmd_valid`/`cmd_code`, so that something outside the block can carry out special commands.

Top module: `twi_ptr_target`

## Requirements
- R1: Every byte moves MSB first, one bit per SCL high phase. The ninth clock of each byte is the acknowledge slot, where low means ACK and high means NACK.
- R2: The target changes its SDA enable only while SCL is low. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A repeated START that comes without a STOP begins a new address phase. After a STOP the target has released SDA.
- R3: An address byte whose upper seven bits equal `DEV_ADDR` is ACKed, and its bit 0 selects read (1) or write (0).
- R4: After an address byte that does not match, the target does not ACK, keeps SDA released and ignores every later bit, pointer and data byte until the next START or STOP.
- R5: A pointer byte of value 0x00 to 0x03 is ACKed and sets `reg_sel` to its low two bits (0 temperature, 1 configuration, 2 low threshold, 3 high threshold). `reg_sel` resets to 0 and keeps its value across transactions.
- R6: A pointer byte of value 0x04 or above is ACKed and produces one `cmd_valid` pulse with the byte on `cmd_code`. It leaves `reg_sel` unchanged, and every data byte that follows it in the same transaction is NACKed.
- R7: With configuration (1) selected, one data byte is ACKed and produces one `reg_wr_en` pulse with data {byte, 0x00}. Any further data byte is NACKed and does not write.
- R8: With a threshold (2 or 3) selected, two data bytes are ACKed and produce one `reg_wr_en` pulse after the second, with data {first, second}. A transaction that stops after only one byte writes nothing. Data bytes sent while temperature (0) is selected are NACKed and write nothing.
- R9: A read starts driving `reg_rd_data[15:8]` in the bit period right after the address ACK, using the stored selection. On a two-byte register, a controller ACK is followed by the low byte as it stood when the high byte was loaded. A controller NACK makes the target release SDA.
- R10: When configuration is read, the target releases SDA after its single byte, whatever the controller answers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as observed |
| sda_i | input | 1 | Bus data line as observed |
| sda_oe | output | 1 | When high, SDA is pulled low |
| reg_sel | output | 2 | Stored register selection |
| reg_rd_data | input | 16 | Contents of the selected register |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_data | output | 16 | Write value, high byte first on the bus |
| cmd_valid | output | 1 | Single-cycle opcode strobe |
| cmd_code | output | 8 | Opcode byte received in the pointer slot |

## Verification
The stimulus drives the bus the way a controller would, using several transaction shapes. These are: a pointer write followed by data, a read that skips the pointer phase, a pointer write followed by a repeated START, a read ended by an early NACK, and transactions sent to a foreign address. Each shape separates a different part of the design. The data length depends on the selected register, which tells the configuration case from the threshold case. A read issued without a pointer phase shows whether the selection really persists. A NACK given before the last byte shows whether the target stops driving. A foreign address shows whether the following pointer and data bytes leak into `reg_sel` or into writes. The register contents are changed between the high byte and the low byte of a read, which shows whether the low byte comes from a snapshot taken when the high byte was loaded.

// File: rtl/twi_ptr_pkg.sv
package twi_ptr_pkg;

  localparam int ADDR_W    = 7;
  localparam int BYTE_BITS = 8;
  localparam int REG_W     = 2 * BYTE_BITS;
  localparam int SEL_W     = 2;
  localparam int CNT_W     = $clog2(BYTE_BITS + 2);

  localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] CNT_SLOT = CNT_W'(BYTE_BITS + 1);

  localparam logic [SEL_W-1:0] SEL_TEMP = 2'd0;
  localparam logic [SEL_W-1:0] SEL_CFG  = 2'd1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ADDR, PH_PTR, PH_WR, PH_RD, PH_IGN
  } phase_t;

  // number of data bytes accepted on a write to this register
  function automatic logic [1:0] wr_len(input logic [SEL_W-1:0] sel);
    if (sel == SEL_TEMP)     return 2'd0;
    else if (sel == SEL_CFG) return 2'd1;
    else                     return 2'd2;
  endfunction

  // number of data bytes offered on a read of this register
  function automatic logic [1:0] rd_len(input logic [SEL_W-1:0] sel);
    return (sel == SEL_CFG) ? 2'd1 : 2'd2;
  endfunction

  // pointer byte names a register rather than an opcode
  function automatic logic is_select(input logic [BYTE_BITS-1:0] b);
    return b[BYTE_BITS-1:SEL_W] == '0;
  endfunction

  // bit to present after `done` bits of a byte have been clocked out
  function automatic logic tx_bit(input logic [BYTE_BITS-1:0] b,
                                  input logic [CNT_W-1:0] done);
    return b[3'd7 - done[2:0]];
  endfunction

endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '1;
          else        r <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) r <= '1;
          else        r <= g_stage[g-1].r;
        end
      end
    end
  endgenerate

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/twi_cond_det.sv
module twi_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_evt = scl_q & scl_s & sda_q & ~sda_s;
  assign stop_evt  = scl_q & scl_s & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;

endmodule

// File: rtl/twi_rx_frame.sv
module twi_rx_frame
  import twi_ptr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 scl_rise,
  input  logic                 scl_fall,
  input  logic                 sda_s,
  output logic [CNT_W-1:0]     cnt,
  output logic [BYTE_BITS-1:0] rx_byte,
  output logic                 ack_bit,
  output logic                 byte_end,
  output logic                 slot_end
);

  // falling edge after the eighth data bit, and after the acknowledge slot
  assign byte_end = scl_fall && (cnt == CNT_BYTE);
  assign slot_end = scl_fall && (cnt == CNT_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      rx_byte <= '0;
      ack_bit <= 1'b1;
    end else if (clr || slot_end) begin
      cnt <= '0;
    end else if (scl_rise) begin
      if (cnt < CNT_BYTE)
        rx_byte <= {rx_byte[BYTE_BITS-2:0], sda_s};
      else if (cnt == CNT_BYTE)
        ack_bit <= sda_s;
      if (cnt != CNT_SLOT)
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/twi_ptr_target.sv
module twi_ptr_target
  import twi_ptr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] DEV_ADDR    = 7'h48,
  parameter int                SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  output logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_rd_data,
  output logic             reg_wr_en,
  output logic [REG_W-1:0] reg_wr_data,
  output logic             cmd_valid,
  output logic [7:0]       cmd_code
);

  // named internal events
  logic [1:0]           sync_q;
  logic                 scl_s, sda_s;
  logic                 start_evt, stop_evt, scl_rise, scl_fall;
  logic [CNT_W-1:0]     cnt;
  logic [BYTE_BITS-1:0] rx_byte;
  logic                 ack_bit, byte_end, slot_end;
  logic                 addr_hit;

  phase_t               phase;
  logic                 rw;
  logic [1:0]           wr_idx;
  logic                 rd_idx;
  logic [BYTE_BITS-1:0] hold_hi, snap_lo, tx_byte;

  twi_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  twi_cond_det u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  twi_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .clr(start_evt | stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .cnt(cnt), .rx_byte(rx_byte), .ack_bit(ack_bit),
    .byte_end(byte_end), .slot_end(slot_end)
  );

  assign addr_hit = (rx_byte[BYTE_BITS-1:1] == DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      sda_oe      <= 1'b0;
      rw          <= 1'b0;
      reg_sel     <= SEL_TEMP;
      wr_idx      <= '0;
      rd_idx      <= 1'b0;
      hold_hi     <= '0;
      snap_lo     <= '0;
      tx_byte     <= '0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      cmd_valid   <= 1'b0;
      cmd_code    <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      cmd_valid <= 1'b0;
      if (start_evt) begin
        phase  <= PH_ADDR;
        sda_oe <= 1'b0;
      end else if (stop_evt) begin
        phase  <= PH_IDLE;
        sda_oe <= 1'b0;
      end else if (byte_end) begin
        // decide the acknowledge for the byte just received
        unique case (phase)
          PH_ADDR: begin
            if (addr_hit) begin
              sda_oe <= 1'b1;
              rw     <= rx_byte[0];
            end else begin
              phase  <= PH_IGN;
              sda_oe <= 1'b0;
            end
          end
          PH_PTR: begin
            sda_oe <= 1'b1;
            if (is_select(rx_byte)) begin
              reg_sel <= rx_byte[SEL_W-1:0];
              wr_idx  <= 2'd0;
            end else begin
              cmd_valid <= 1'b1;
              cmd_code  <= rx_byte;
              wr_idx    <= 2'd2;
            end
          end
          PH_WR: begin
            if (wr_idx < wr_len(reg_sel)) begin
              sda_oe <= 1'b1;
              wr_idx <= wr_idx + 2'd1;
              if (wr_idx == 2'd0) hold_hi <= rx_byte;
              if (wr_idx + 2'd1 == wr_len(reg_sel)) begin
                reg_wr_en   <= 1'b1;
                reg_wr_data <= (wr_idx == 2'd0) ? {rx_byte, 8'h00}
                                                : {hold_hi, rx_byte};
              end
            end else begin
              sda_oe <= 1'b0;
            end
          end
          PH_RD:   sda_oe <= 1'b0;
          default: sda_oe <= 1'b0;
        endcase
      end else if (slot_end) begin
        // acknowledge slot over: set up the next byte
        unique case (phase)
          PH_ADDR: begin
            if (rw) begin
              phase   <= PH_RD;
              rd_idx  <= 1'b0;
              tx_byte <= reg_rd_data[REG_W-1:BYTE_BITS];
              snap_lo <= reg_rd_data[BYTE_BITS-1:0];
              sda_oe  <= ~reg_rd_data[REG_W-1];
            end else begin
              phase  <= PH_PTR;
              sda_oe <= 1'b0;
            end
          end
          PH_PTR: begin
            phase  <= PH_WR;
            sda_oe <= 1'b0;
          end
          PH_RD: begin
            if (!ack_bit && !rd_idx && rd_len(reg_sel) == 2'd2) begin
              rd_idx  <= 1'b1;
              tx_byte <= snap_lo;
              sda_oe  <= ~snap_lo[BYTE_BITS-1];
            end else begin
              phase  <= PH_IGN;
              sda_oe <= 1'b0;
            end
          end
          default: sda_oe <= 1'b0;
        endcase
      end else if (scl_fall && phase == PH_RD && cnt != '0 && cnt < CNT_BYTE) begin
        sda_oe <= ~tx_bit(tx_byte, cnt);
      end
    end
  end

endmodule

// File: rtl/twi_ptr_target_chk.sv
module twi_ptr_target_chk
  import twi_ptr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             sda_oe,
  input logic             scl_s,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             byte_end,
  input logic             addr_hit,
  input phase_t           phase,
  input logic [SEL_W-1:0] reg_sel,
  input logic             reg_wr_en,
  input logic             cmd_valid
);

  p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  p_release_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  p_ack_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && phase == PH_ADDR && addr_hit) |=> sda_oe);

  p_ignored_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGN) |-> !sda_oe);

  p_sel_moves_at_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sel) |-> $past(byte_end));

  p_cmd_keeps_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $stable(reg_sel));

  p_cmd_wr_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && reg_wr_en));

  p_wr_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en);

endmodule

bind twi_ptr_target twi_ptr_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_s(scl_s),
  .start_evt(start_evt), .stop_evt(stop_evt), .byte_end(byte_end),
  .addr_hit(addr_hit), .phase(phase), .reg_sel(reg_sel),
  .reg_wr_en(reg_wr_en), .cmd_valid(cmd_valid)
);

// File: tb/twi_ptr_target_bench.sv
module twi_ptr_target_bench;

  localparam int         QTR  = 10;
  localparam logic [6:0] ADDR = 7'h48;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        scl_drv = 1'b1, sda_drv = 1'b1;
  logic        sda_oe, reg_wr_en, cmd_valid;
  logic [1:0]  reg_sel;
  logic [15:0] reg_rd_data, reg_wr_data;
  logic [7:0]  cmd_code;
  logic [15:0] regs [4];
  wire         sda_bus = sda_drv & ~sda_oe;

  assign reg_rd_data = regs[reg_sel];

  twi_ptr_target #(.DEV_ADDR(ADDR)) u_twi_ptr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
    .sda_oe(sda_oe), .reg_sel(reg_sel), .reg_rd_data(reg_rd_data),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code)
  );

  always #10 clk = ~clk;

  int          vectors = 0, errors = 0, hi_cnt = 0;
  logic        exp_oe = 1'b0;
  logic [1:0]  exp_sel = 2'd0;
  logic [17:0] wr_q [$];
  logic [7:0]  cmd_q [$];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model: expected drive and selection, compared mid-high of every SCL pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_drv) hi_cnt++;
      else         hi_cnt = 0;
      if (hi_cnt == QTR) begin
        check("R2 sda drive per bit", {31'd0, sda_oe}, {31'd0, exp_oe});
        check("R5 stored selection", {30'd0, reg_sel}, {30'd0, exp_sel});
      end
      if (reg_wr_en) begin
        if (wr_q.size() == 0) check("R7 R8 unexpected write", {14'd0, reg_sel, reg_wr_data}, 32'hFFFF_FFFF);
        else check("R7 R8 write data", {14'd0, reg_sel, reg_wr_data}, {14'd0, wr_q.pop_front()});
        regs[reg_sel] = reg_wr_data;
      end
      if (cmd_valid) begin
        if (cmd_q.size() == 0) check("R6 unexpected opcode", {24'd0, cmd_code}, 32'hFFFF_FFFF);
        else check("R6 opcode", {24'd0, cmd_code}, {24'd0, cmd_q.pop_front()});
      end
    end
  end

  task automatic wait_q(input int n);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    exp_oe = 1'b0;
    sda_drv = 1'b1; wait_q(1);
    scl_drv = 1'b1; wait_q(1);
    sda_drv = 1'b0; wait_q(1);
    scl_drv = 1'b0; wait_q(1);
  endtask

  task automatic bus_stop();
    exp_oe = 1'b0;
    sda_drv = 1'b0; wait_q(1);
    scl_drv = 1'b1; wait_q(1);
    sda_drv = 1'b1; wait_q(2);
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    sda_drv = b;    wait_q(1);
    scl_drv = 1'b1; wait_q(1);
    seen = sda_bus; wait_q(1);
    scl_drv = 1'b0; wait_q(1);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req, input int new_sel);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      exp_oe = 1'b0;
      clk_bit(b[i], s);
    end
    if (new_sel >= 0) exp_sel = new_sel[1:0];
    exp_oe = exp_ack;
    clk_bit(1'b1, s);
    check(req, {31'd0, s}, {31'd0, ~exp_ack});
    exp_oe = 1'b0;
  endtask

  task automatic recv_byte(input logic [7:0] exp, input logic ctrl_ack, input string req);
    logic [7:0] got;
    logic s;
    for (int i = 7; i >= 0; i--) begin
      exp_oe = ~exp[i];
      clk_bit(1'b1, s);
      got[i] = s;
    end
    check(req, {24'd0, got}, {24'd0, exp});
    exp_oe = 1'b0;
    clk_bit(~ctrl_ack, s);
  endtask

  initial begin
    regs[0] = 16'h0C80; regs[1] = 16'h0000; regs[2] = 16'h4B00; regs[3] = 16'h5A3C;
    repeat (5) @(negedge clk);
    check("R5 reset selection", {30'd0, reg_sel}, 32'd0);
    check("R2 reset released", {31'd0, sda_oe}, 32'd0);
    check("R7 reset no write", {30'd0, reg_wr_en, cmd_valid}, 32'd0);
    rst_n = 1'b1;
    wait_q(2);

    // threshold write
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R3 write address ack", -1);
    send_byte(8'h02, 1'b1, "R5 select low threshold", 2);
    send_byte(8'h12, 1'b1, "R8 first threshold byte", -1);
    wr_q.push_back({2'd2, 16'h1234});
    send_byte(8'h34, 1'b1, "R8 second threshold byte", -1);
    bus_stop();
    check("R8 threshold write seen", wr_q.size(), 0);

    // read with no pointer phase
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R3 read address ack", -1);
    recv_byte(8'h12, 1'b1, "R1 R9 high byte MSB first");
    recv_byte(8'h34, 1'b0, "R9 low byte after ACK");
    bus_stop();

    // configuration write with an extra byte
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R3 write address ack", -1);
    send_byte(8'h01, 1'b1, "R5 select configuration", 1);
    wr_q.push_back({2'd1, 16'hA500});
    send_byte(8'hA5, 1'b1, "R7 config byte ack", -1);
    send_byte(8'h77, 1'b0, "R7 extra byte nacked", -1);
    bus_stop();
    check("R7 single config write", wr_q.size(), 0);

    // configuration read, controller ACKs anyway
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R3 read address ack", -1);
    recv_byte(8'hA5, 1'b1, "R1 R10 config byte");
    recv_byte(8'hFF, 1'b0, "R10 released after one byte");
    bus_stop();

    // pointer then repeated START read
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R3 write address ack", -1);
    send_byte(8'h03, 1'b1, "R5 select high threshold", 3);
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R2 address after repeated start", -1);
    recv_byte(8'h5A, 1'b1, "R9 high threshold msb");
    recv_byte(8'h3C, 1'b0, "R9 high threshold lsb");
    bus_stop();

    // early NACK
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R3 read address ack", -1);
    recv_byte(8'h5A, 1'b0, "R9 msb then NACK");
    recv_byte(8'hFF, 1'b0, "R9 released after NACK");
    bus_stop();

    // foreign address, write then read
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, 1'b0, "R4 foreign address not acked", -1);
    send_byte(8'h01, 1'b0, "R4 pointer ignored", -1);
    send_byte(8'h55, 1'b0, "R4 data ignored", -1);
    bus_stop();
    bus_start();
    send_byte({ADDR ^ 7'h10, 1'b1}, 1'b0, "R4 foreign read not acked", -1);
    recv_byte(8'hFF, 1'b0, "R4 no data driven");
    bus_stop();
    check("R4 no write from foreign", wr_q.size(), 0);

    // opcode in pointer slot
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R3 write address ack", -1);
    cmd_q.push_back(8'hB8);
    send_byte(8'hB8, 1'b1, "R6 opcode acked", -1);
    send_byte(8'h11, 1'b0, "R6 data after opcode nacked", -1);
    bus_stop();
    check("R6 opcode seen", cmd_q.size(), 0);

    // temperature is read-only
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R3 write address ack", -1);
    send_byte(8'h00, 1'b1, "R5 select temperature", 0);
    send_byte(8'h99, 1'b0, "R8 temperature write nacked", -1);
    bus_stop();

    // snapshot of low byte
    regs[0] = 16'h1980;
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R3 read address ack", -1);
    regs[0] = 16'hFFFF;
    recv_byte(8'h19, 1'b1, "R9 temperature msb");
    recv_byte(8'h80, 1'b0, "R9 low byte from snapshot");
    bus_stop();

    // threshold write cut short
    bus_start();
    send_byte({ADDR, 1'b0}, 1'b1, "R3 write address ack", -1);
    send_byte(8'h02, 1'b1, "R5 select low threshold", 2);
    send_byte(8'h44, 1'b1, "R8 lone threshold byte", -1);
    bus_stop();
    bus_start();
    send_byte({ADDR, 1'b1}, 1'b1, "R3 read address ack", -1);
    recv_byte(8'h12, 1'b1, "R8 partial write left msb");
    recv_byte(8'h34, 1'b0, "R8 partial write left lsb");
    bus_stop();

    check("R7 R8 no pending writes", wr_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule